// File: doc/BRIEF.md
# Display RAM Host Port with Pipelined Bus Holder

This block connects an 8-bit host parallel bus to a small on-chip display data RAM. Every transfer passes through a single holding register, the bus holder. Because of this the host only has to meet its strobe cycle time and never waits. A display-data write is posted into the holder and committed to RAM in the following clock. A display-data read is always one access behind. It drives the holder's current contents onto the bus. On the strobe's trailing edge it refills the holder from the current column and advances the column.

The host selects the port with an active-low and an active-high select. The register-select line `a0` separates display data (high) from commands (low). The only command decoded here loads the column address. Strobes, the select, `a0` and the data byte all pass through the same synchronizer, so they arrive aligned in the clock domain. An access is taken on the rising edge of the synchronized strobe. The bus driver enable is formed directly from the pins, so the host sees data while its read strobe is low.

Top module: `dram_hold_port`

## Requirements
- R1: Reset clears every RAM location, the holder and the column address to zero. After reset `data_oe` is low, and the first display read returns 0x00.
- R2: The port is selected only when `cs1_n` is 0 and `cs2` is 1. Strobes given while it is not selected change no RAM location, column or holder contents, and they do not drive the bus.
- R3: `data_oe` is 1 exactly while the port is selected, `rd_n` is 0 and `a0` is 1. While it is 1, `data_out` shows the holder.
- R4: A display write (`a0`=1, rising `wr_n`) places the byte in the holder. One clock later the byte is stored at the current column and the column increments.
- R5: A display read drives the holder's contents. On rising `rd_n` the holder reloads from RAM at the current column and the column increments.
- R6: The first display read after a column load returns whatever the holder held before. It is a dummy read.
- R7: The first display read after a display write returns the byte just written, not the RAM at the new column.
- R8: A command write (`a0`=0) whose bit 7 is 1 loads the column from its low ADDR_W bits. A command whose bit 7 is 0 leaves the column unchanged.
- R9: The column wraps from DEPTH-1 to 0 on both write commits and read reloads.
- R10: A read with `a0`=0 leaves `data_oe` low and changes neither the holder nor the column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs1_n | input | 1 | Select, active low |
| cs2 | input | 1 | Select, active high |
| a0 | input | 1 | 1 = display data, 0 = command |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| data_in | input | 8 | Byte from the host bus |
| data_out | output | 8 | Byte toward the host bus (holder contents) |
| data_oe | output | 1 | Host bus driver enable |

## Verification
The hardest case to reach is the stale holder. What a read returns depends on the last access, not only on the current column. The stimulus deliberately strings together column loads, writes, ignored commands, deselected strobes and command-side reads, and then follows each with a dummy read. This shows which of these refreshed the holder. The column wrap is reached by loading the last column and writing or reading across it.

// File: rtl/dram_pkg.sv
// Package: shared types and command decoding for the display RAM host port.
// Assumes byte-wide host data; the column field fits in the low 7 bits.
package dram_pkg;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_DWR  = 2'd1,
        OP_CMD  = 2'd2,
        OP_DRD  = 2'd3
    } host_op_e;

    // True when a command byte asks for a column load.
    function automatic logic is_col_set(input logic [7:0] cmd);
        return cmd[7];
    endfunction

endpackage

// File: rtl/dram_sync.sv
// Module: multi-stage synchronizer for a bundle of asynchronous host pins.
// Assumes the bundle members are held long enough to be sampled together.
module dram_sync #(
    parameter int            W       = 1,
    parameter int            STAGES  = 2,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            // First stage samples the pins.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[0] <= RST_VAL;
                else        stg[0] <= din;
            end
        end else begin : g_next
            // Later stages shift the sample along.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[i] <= RST_VAL;
                else        stg[i] <= stg[i-1];
            end
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/dram_rise_det.sv
// Module: one-cycle pulse on the rising (trailing) edge of an active-low strobe.
// Assumes the input is already synchronized; idle level is high.
module dram_rise_det (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise
);
    logic prev;

    // Remember last level to spot low-to-high.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b1;
        else        prev <= lvl;
    end

    assign rise = lvl & ~prev;
endmodule

// File: rtl/dram_col_addr.sv
// Module: column address register with load and wrapping increment.
// Assumes load and increment never coincide (host strobes are sequential).
module dram_col_addr #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              inc,
    output logic [ADDR_W-1:0] col
);
    // Load wins, otherwise advance modulo 2**ADDR_W.
    always_ff @(posedge clk) begin
        if (!rst_n)    col <= '0;
        else if (load) col <= load_val;
        else if (inc)  col <= col + 1'b1;
    end

    // R8: a load takes the commanded column.
    p_col_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> col == $past(load_val));

    // R9: increments wrap through the top column.
    p_col_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !load) |=> col == ADDR_W'($past(col) + 1'b1));

    // R10: no request leaves the column alone.
    p_col_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !load) |=> $stable(col));
endmodule

// File: rtl/dram_array.sv
// Module: display data RAM, one synchronous write port, one combinational read.
// Assumes DEPTH = 2**ADDR_W; reset clears all locations.
module dram_array #(
    parameter int ADDR_W = 6,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);
    logic [7:0] mem [DEPTH];

    // Clear on reset, otherwise store committed bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

    // R4: a commit lands at the address it was issued for.
    p_commit_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> mem[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/dram_hold_port.sv
// Module: host port to the display RAM through a one-entry bus holder.
// Writes post into the holder and commit next clock; reads return the holder
// and refill it from the current column. Assumes the host holds a0, data and
// selects across its strobe's rising edge and spaces strobes a few clocks apart.
module dram_hold_port #(
    parameter int ADDR_W      = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs1_n,
    input  logic       cs2,
    input  logic       a0,
    input  logic       rd_n,
    input  logic       wr_n,
    input  logic [7:0] data_in,
    output logic [7:0] data_out,
    output logic       data_oe
);
    import dram_pkg::*;

    localparam int BUS_W  = 12;
    localparam int N_STRB = 2;
    localparam logic [BUS_W-1:0] BUS_IDLE = {1'b1, 1'b1, 1'b0, 1'b0, 8'h00};

    logic              sel_raw;
    logic [BUS_W-1:0]  bus_s;
    logic [N_STRB-1:0] strb_s, strb_rise;
    logic              sel_s, a0_s;
    logic [7:0]        din_s;
    host_op_e          op;
    logic [7:0]        holder;
    logic              pend;
    logic [ADDR_W-1:0] col;
    logic [7:0]        rd_data;

    assign sel_raw = ~cs1_n & cs2;

    dram_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL(BUS_IDLE)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({rd_n, wr_n, sel_raw, a0, data_in}),
        .dout (bus_s)
    );

    assign strb_s = bus_s[11:10];
    assign sel_s  = bus_s[9];
    assign a0_s   = bus_s[8];
    assign din_s  = bus_s[7:0];

    for (genvar s = 0; s < N_STRB; s++) begin : g_strb
        dram_rise_det u_rise (
            .clk  (clk),
            .rst_n(rst_n),
            .lvl  (strb_s[s]),
            .rise (strb_rise[s])
        );
    end

    // Classify the access taken on this clock (bit 1 = read, bit 0 = write).
    always_comb begin
        op = OP_NONE;
        if (sel_s && strb_rise[0]) op = a0_s ? OP_DWR : OP_CMD;
        else if (sel_s && strb_rise[1] && a0_s) op = OP_DRD;
    end

    // Bus holder: capture posted writes, refill after display reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            holder <= '0;
            pend   <= 1'b0;
        end else begin
            pend <= (op == OP_DWR);
            if (op == OP_DWR)      holder <= din_s;
            else if (op == OP_DRD) holder <= rd_data;
        end
    end

    dram_col_addr #(.ADDR_W(ADDR_W)) u_col (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    ((op == OP_CMD) && is_col_set(din_s)),
        .load_val(din_s[ADDR_W-1:0]),
        .inc     (pend || (op == OP_DRD)),
        .col     (col)
    );

    dram_array #(.ADDR_W(ADDR_W)) u_ram (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (pend),
        .waddr(col),
        .wdata(holder),
        .raddr(col),
        .rdata(rd_data)
    );

    assign data_out = holder;
    assign data_oe  = sel_raw & ~rd_n & a0;

    // R4: a posted write is committed on exactly one clock.
    p_single_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pend |=> !pend);

    // R5: a display read refills the holder from RAM.
    p_read_refill_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_DRD) |=> holder == $past(rd_data));

    // R10: with no data access the holder keeps its contents.
    p_holder_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_NONE || op == OP_CMD) |=> $stable(holder));

    // R2: a deselected port never drives the bus.
    p_deselect_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cs1_n || !cs2) |-> !data_oe);
endmodule

// File: tb/sim_dram_hold_port.sv
// Scoreboard bench: driver tasks update a reference model and queue expected
// bus values; a monitor pops and compares them while the read strobe is low.
module sim_dram_hold_port;
    localparam int ADDR_W = 6;
    localparam int DEPTH  = 1 << ADDR_W;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs1_n = 1'b1, cs2 = 1'b0, a0 = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
    logic [7:0] data_in = '0;
    logic [7:0] data_out;
    logic       data_oe;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0]        m_mem [DEPTH];
    logic [ADDR_W-1:0] m_col;
    logic [7:0]        m_hold;

    logic [7:0] q_val [$];
    logic       q_oe  [$];
    string      q_tag [$];
    event       mon_ev;

    always #2.5 clk = ~clk;

    dram_hold_port #(.ADDR_W(ADDR_W), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .cs1_n(cs1_n), .cs2(cs2), .a0(a0),
        .rd_n(rd_n), .wr_n(wr_n), .data_in(data_in),
        .data_out(data_out), .data_oe(data_oe)
    );

    // Monitor: compare the bus with the oldest queued expectation.
    initial forever begin
        @(mon_ev);
        if (q_val.size() != 0) begin
            logic [7:0] ev;
            logic       eo;
            string      tg;
            ev = q_val.pop_front();
            eo = q_oe.pop_front();
            tg = q_tag.pop_front();
            checks++;
            if (data_oe !== eo || (eo && data_out !== ev)) begin
                errors++;
                $display("FAIL %s: oe=%0b data=%02h expected oe=%0b data=%02h",
                         tg, data_oe, data_out, eo, ev);
            end
        end
    end

    task automatic bus_write(input logic s1n, input logic s2, input logic ad,
                             input logic [7:0] d);
        @(negedge clk);
        cs1_n = s1n; cs2 = s2; a0 = ad; data_in = d; wr_n = 1'b0;
        repeat (3) @(negedge clk);
        wr_n = 1'b1;
        repeat (4) @(negedge clk);
        cs1_n = 1'b1; cs2 = 1'b0;
        repeat (2) @(negedge clk);
        if (!s1n && s2) begin
            if (ad) begin
                m_hold = d; m_mem[m_col] = d; m_col = m_col + 1'b1;
            end else if (d[7]) begin
                m_col = d[ADDR_W-1:0];
            end
        end
    endtask

    task automatic bus_read(input logic s1n, input logic s2, input logic ad,
                            input string tag);
        logic live;
        live = !s1n && s2;
        @(negedge clk);
        cs1_n = s1n; cs2 = s2; a0 = ad; rd_n = 1'b0;
        repeat (3) @(negedge clk);
        q_val.push_back(m_hold);
        q_oe.push_back(live && ad);
        q_tag.push_back(tag);
        -> mon_ev;
        @(negedge clk);
        rd_n = 1'b1;
        repeat (4) @(negedge clk);
        cs1_n = 1'b1; cs2 = 1'b0;
        repeat (2) @(negedge clk);
        if (live && ad) begin
            m_hold = m_mem[m_col]; m_col = m_col + 1'b1;
        end
    endtask

    task automatic col_set(input logic [ADDR_W-1:0] c);
        bus_write(1'b0, 1'b1, 1'b0, 8'h80 | 8'(c));
    endtask

    task automatic dread(input string tag);
        bus_read(1'b0, 1'b1, 1'b1, tag);
    endtask

    task automatic dwrite(input logic [7:0] d);
        bus_write(1'b0, 1'b1, 1'b1, d);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) m_mem[i] = 8'h00;
        m_col = '0; m_hold = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: bus released after reset.
        checks++;
        if (data_oe !== 1'b0) begin
            errors++;
            $display("FAIL R1: oe=%0b expected oe=0", data_oe);
        end
        dread("R1 first read after reset");
        dread("R1 cleared RAM");

        // R4, R5, R6: writes then readback with a dummy read.
        col_set(6'd5);
        dwrite(8'hAA); dwrite(8'hBB); dwrite(8'hCC);
        col_set(6'd5);
        dread("R6 dummy after column load");
        dread("R5 read col5"); dread("R5 read col6"); dread("R4 committed col7");

        // R7: read right after a write returns the written byte.
        dwrite(8'hDD);
        dread("R7 read after write");
        dread("R4 next column after write");

        // R9: wrap on writes and on reads.
        col_set(6'd63);
        dwrite(8'h11); dwrite(8'h22);
        col_set(6'd63);
        dread("R9 dummy"); dread("R9 col63"); dread("R9 col0 after wrap");

        // R8: non-load command leaves the column unchanged.
        col_set(6'd10);
        dwrite(8'h33);
        bus_write(1'b0, 1'b1, 1'b0, 8'h15);
        dwrite(8'h44);
        col_set(6'd10);
        dread("R8 dummy"); dread("R8 col10"); dread("R8 col11 unchanged column");

        // R2: deselected writes and reads have no effect.
        col_set(6'd12);
        bus_write(1'b1, 1'b1, 1'b1, 8'h99);
        bus_write(1'b0, 1'b0, 1'b1, 8'h98);
        bus_write(1'b1, 1'b1, 1'b0, 8'h85);
        bus_read(1'b1, 1'b1, 1'b1, "R2 cs1 high no drive");
        bus_read(1'b0, 1'b0, 1'b1, "R3 cs2 low no drive");
        dread("R2 holder untouched");
        dread("R2 col12 not written");

        // R10: command-side read does not drive nor move anything.
        col_set(6'd5);
        dread("R10 dummy");
        bus_read(1'b0, 1'b1, 1'b0, "R10 a0 low no drive");
        dread("R10 col5 still next");
        dread("R3 col6 drive");

        repeat (4) @(negedge clk);
        if (q_val.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: %0d left, expected 0", q_val.size());
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule